// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads a three-level radix page table from memory, one level at a time. A consumer presents the virtual address on a valid/ready request port. Alongside it, the consumer presents the page number of the root table, which comes from the core's translation base register.

The walker checks that the untranslated high bits are clear. It then issues one 64-bit read per level, from level 2 down to level 0, and only one read is ever in flight. It finishes with either the physical address and the leaf entry's flags, or a fault.

The result stays on the result port until the consumer acknowledges it. Only then does the walker accept another request. A synchronous, active-high reset abandons any walk that is in progress.

Top module: `xlat_walker`

## Requirements
- R1: If any virtual address bit from 63 down to 39 is set, the walk ends with a fault and issues no memory read. A faulted result shows physical address 0 and flags 0.
- R2: The level-2 index is virtual address bits 38:30, the level-1 index is bits 29:21, and the level-0 index is bits 20:12. The reads go strictly in the order level 2, level 1, level 0.
- R3: Each read address is the table base plus the 9-bit index times 8, where a table base is a 4096-byte-aligned page. The first base is the root page number shifted left by 12. Every later base is the previous entry's page number (entry bits 53:10) shifted left by 12, and entry bits 63:54 have no effect.
- R4: If the level-2 or level-1 entry has its valid flag (entry bit 0) clear, the walk faults with no further reads. That is exactly 1 read for level 2 and exactly 2 reads for level 1.
- R5: If the level-0 entry has its valid flag clear, the walk faults after exactly 3 reads, whatever its other flag bits are.
- R6: On success, the physical address is the level-0 page number shifted left by 12, ORed with virtual address bits 11:0. The flags output is level-0 entry bits 9:0, and the fault output is 0.
- R7: The memory port has at most one read outstanding. A pending read request holds its valid signal and its address until it is accepted. A successful walk issues exactly 3 reads, including when the memory stalls.
- R8: The request port is ready only when the walker is idle. A request offered while a walk is busy or a result is held is not taken. The result is held stable until it is acknowledged, and the walker becomes ready on the cycle after the acknowledge.
- R9: While reset is high, the walker is idle: ready high, no read request, no result. This holds even if reset arrives in the middle of a walk, and the next request after reset then walks normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| root_ppn | input | 44 | Page number of the root table, sampled at acceptance |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| res_valid | output | 1 | Result held |
| res_ready | input | 1 | Consumer acknowledges the result |
| res_paddr | output | 56 | Translated physical address (0 on fault) |
| res_flags | output | 10 | Leaf entry flags (0 on fault) |
| res_fault | output | 1 | Walk faulted |

## Verification
The bench builds the walker with its default parameters: 64-bit virtual addresses, three levels of 9-bit indices, 12-bit offsets, and 64-bit entries with 44-bit page numbers and 10 flag bits. With these values, the bench can use the highest index value 511, the all-ones offset, page numbers that fill all 44 bits, and set reserved entry bits. It can also set the lowest and the highest of the untranslated bits (39 and 63). Faults at each of the three levels come from entries whose valid flag is clear, and the memory model can insert ready stalls on alternate cycles.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_ISSUE = 2'd1,
      WK_WAIT  = 2'd2,
      WK_DONE  = 2'd3
   } walk_st_e;
endpackage

// File: rtl/xlat_entry_addr.sv
module xlat_entry_addr #(
   parameter int LEVELS = 3,
   parameter int IDX_W  = 9,
   parameter int OFF_W  = 12,
   parameter int PPN_W  = 44,
   parameter int ENT_SH = 3,
   parameter int LVL_W  = 2,
   localparam int VPN_W = LEVELS * IDX_W,
   localparam int PA_W  = PPN_W + OFF_W
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] lvl,
   input  logic [PPN_W-1:0] base_ppn,
   output logic [PA_W-1:0]  entry_addr
);
   logic [IDX_W-1:0] idx_arr [LEVELS];
   logic [IDX_W-1:0] idx_sel;

   for (genvar l = 0; l < LEVELS; l++) begin : g_idx
      assign idx_arr[l] = vpn[l*IDX_W +: IDX_W];
   end

   always_comb begin
      idx_sel = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (lvl == LVL_W'(l)) idx_sel = idx_arr[l];
      end
   end

   // aligned base: index times entry size fills the low bits exactly
   assign entry_addr = {base_ppn, idx_sel, {ENT_SH{1'b0}}};
endmodule

// File: rtl/xlat_pte_dec.sv
module xlat_pte_dec #(
   parameter int PTE_W  = 64,
   parameter int PPN_W  = 44,
   parameter int FLAG_W = 10,
   parameter int V_BIT  = 0
) (
   input  logic [PTE_W-1:0]  pte,
   output logic              pte_v,
   output logic [PPN_W-1:0]  pte_ppn,
   output logic [FLAG_W-1:0] pte_flags
);
   assign pte_v     = pte[V_BIT];
   assign pte_flags = pte[FLAG_W-1:0];
   assign pte_ppn   = pte[FLAG_W +: PPN_W];

   if (PTE_W > FLAG_W + PPN_W) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^pte[PTE_W-1:FLAG_W+PPN_W];
   end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
   parameter int VA_W   = 64,
   parameter int LEVELS = 3,
   parameter int IDX_W  = 9,
   parameter int OFF_W  = 12,
   parameter int PTE_W  = 64,
   parameter int PPN_W  = 44,
   parameter int FLAG_W = 10,
   parameter int V_BIT  = 0,
   localparam int XLAT_W = OFF_W + LEVELS * IDX_W,
   localparam int PA_W   = PPN_W + OFF_W,
   localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int ENT_SH = $clog2(PTE_W / 8)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [PPN_W-1:0]  root_ppn,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data,
   output logic              res_valid,
   input  logic              res_ready,
   output logic [PA_W-1:0]   res_paddr,
   output logic [FLAG_W-1:0] res_flags,
   output logic              res_fault
);
   import xlat_pkg::*;

   if (XLAT_W > VA_W) begin : g_bad_va
      $error("translated field wider than the virtual address");
   end
   if (IDX_W + ENT_SH != OFF_W) begin : g_bad_tbl
      $error("a table must fill exactly one page");
   end
   if (FLAG_W + PPN_W > PTE_W) begin : g_bad_pte
      $error("entry too narrow for page number and flags");
   end
   if (V_BIT >= FLAG_W) begin : g_bad_vbit
      $error("valid flag outside the flag field");
   end

   walk_st_e            st_q;
   logic [LVL_W-1:0]    lvl_q;
   logic [XLAT_W-1:0]   va_q;
   logic [PPN_W-1:0]    base_q;
   logic [PA_W-1:0]     pa_q;
   logic [FLAG_W-1:0]   fl_q;
   logic                flt_q;
   logic                hi_bad;
   logic                pte_v;
   logic [PPN_W-1:0]    pte_ppn;
   logic [FLAG_W-1:0]   pte_flags;

   if (XLAT_W < VA_W) begin : g_hi_chk
      assign hi_bad = |req_vaddr[VA_W-1:XLAT_W];
   end else begin : g_hi_none
      assign hi_bad = 1'b0;
   end

   xlat_entry_addr #(
      .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W),
      .PPN_W(PPN_W), .ENT_SH(ENT_SH), .LVL_W(LVL_W)
   ) u_ea (
      .vpn        (va_q[XLAT_W-1:OFF_W]),
      .lvl        (lvl_q),
      .base_ppn   (base_q),
      .entry_addr (mem_req_addr)
   );

   xlat_pte_dec #(
      .PTE_W(PTE_W), .PPN_W(PPN_W), .FLAG_W(FLAG_W), .V_BIT(V_BIT)
   ) u_dec (
      .pte       (mem_rsp_data),
      .pte_v     (pte_v),
      .pte_ppn   (pte_ppn),
      .pte_flags (pte_flags)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= WK_IDLE;
         lvl_q  <= '0;
         va_q   <= '0;
         base_q <= '0;
         pa_q   <= '0;
         fl_q   <= '0;
         flt_q  <= 1'b0;
      end else begin
         unique case (st_q)
            WK_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr[XLAT_W-1:0];
                  base_q <= root_ppn;
                  lvl_q  <= LVL_W'(LEVELS - 1);
                  if (hi_bad) begin
                     pa_q  <= '0;
                     fl_q  <= '0;
                     flt_q <= 1'b1;
                     st_q  <= WK_DONE;
                  end else begin
                     st_q  <= WK_ISSUE;
                  end
               end
            end
            WK_ISSUE: begin
               if (mem_req_ready) st_q <= WK_WAIT;
            end
            WK_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!pte_v) begin
                     pa_q  <= '0;
                     fl_q  <= '0;
                     flt_q <= 1'b1;
                     st_q  <= WK_DONE;
                  end else if (lvl_q == '0) begin
                     pa_q  <= {pte_ppn, va_q[OFF_W-1:0]};
                     fl_q  <= pte_flags;
                     flt_q <= 1'b0;
                     st_q  <= WK_DONE;
                  end else begin
                     base_q <= pte_ppn;
                     lvl_q  <= lvl_q - LVL_W'(1);
                     st_q   <= WK_ISSUE;
                  end
               end
            end
            WK_DONE: begin
               if (res_ready) st_q <= WK_IDLE;
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == WK_IDLE);
   assign mem_req_valid = (st_q == WK_ISSUE);
   assign res_valid     = (st_q == WK_DONE);
   assign res_paddr     = pa_q;
   assign res_flags     = fl_q;
   assign res_fault     = flt_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
   parameter int VA_W   = 64,
   parameter int XLAT_W = 39,
   parameter int LEVELS = 3,
   parameter int PA_W   = 56,
   parameter int FLAG_W = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic [VA_W-1:0]   req_vaddr,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [PA_W-1:0]   mem_req_addr,
   input logic              mem_rsp_valid,
   input logic              res_valid,
   input logic              res_ready,
   input logic [PA_W-1:0]   res_paddr,
   input logic [FLAG_W-1:0] res_flags,
   input logic              res_fault
);
   logic       outst_q;
   logic [3:0] rd_q;
   logic       acc;

   assign acc = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         outst_q <= 1'b0;
         rd_q    <= '0;
      end else begin
         if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
         else if (mem_rsp_valid)             outst_q <= 1'b0;
         if (acc)                                  rd_q <= '0;
         else if (mem_req_valid && mem_req_ready)  rd_q <= rd_q + 4'd1;
      end
   end

   AST_CANON_FAULT: assert property (@(posedge clk) disable iff (rst)
      (acc && |req_vaddr[VA_W-1:XLAT_W]) |=> (res_valid && res_fault && !mem_req_valid)); // R1
   AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (rst)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R3
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_fault) |-> (res_paddr == '0 && res_flags == '0)); // R4
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
      outst_q |-> !mem_req_valid); // R7
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
   AST_READ_LIMIT: assert property (@(posedge clk) disable iff (rst)
      rd_q <= 4'(LEVELS)); // R7
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr)
                                     && $stable(res_flags) && $stable(res_fault))); // R8
   AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (!res_valid && !mem_req_valid)); // R8
endmodule

bind xlat_walker xlat_walker_chk #(
   .VA_W(VA_W), .XLAT_W(XLAT_W), .LEVELS(LEVELS), .PA_W(PA_W), .FLAG_W(FLAG_W)
) u_chk (.*);

// File: tb/sim_xlat_walker.sv
`timescale 1ns/1ps
module sim_xlat_walker;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_vaddr = '0;
   logic [43:0] root_ppn = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [55:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        res_valid;
   logic        res_ready = 1'b0;
   logic [55:0] res_paddr;
   logic [9:0]  res_flags;
   logic        res_fault;

   int n_chk = 0;
   int n_bad = 0;
   int rd_cnt = 0;
   logic [55:0] rd_log [4];
   logic [55:0] m_addr [8];
   logic [63:0] m_data [8];
   int m_cnt = 0;
   bit mem_stall = 1'b0;
   bit pend = 1'b0;
   logic [55:0] pend_addr;

   always #4 clk = ~clk;

   xlat_walker u0 (.*);

   function automatic logic [63:0] mkva(input logic [8:0] a2, a1, a0, input logic [11:0] off);
      return {25'b0, a2, a1, a0, off};
   endfunction
   function automatic logic [55:0] ea(input logic [43:0] ppn, input logic [8:0] idx);
      return {ppn, idx, 3'b000};
   endfunction
   function automatic logic [63:0] mkpte(input logic [9:0] rsvd, input logic [43:0] ppn, input logic [9:0] fl);
      return {rsvd, ppn, fl};
   endfunction
   function automatic logic [63:0] lookup(input logic [55:0] a);
      for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) return m_data[i];
      return 64'h0;
   endfunction

   // memory model: one read at a time, data one cycle after acceptance
   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (rst) begin
            pend = 1'b0;
         end else begin
            mem_req_ready = mem_stall ? ~mem_req_ready : 1'b1;
            if (pend) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = lookup(pend_addr);
               pend = 1'b0;
            end else if (mem_req_valid && mem_req_ready) begin
               pend = 1'b1;
               pend_addr = mem_req_addr;
               if (rd_cnt < 4) rd_log[rd_cnt] = mem_req_addr;
               rd_cnt++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic clear_mem();
      m_cnt = 0;
   endtask
   task automatic put(input logic [55:0] a, input logic [63:0] d);
      m_addr[m_cnt] = a;
      m_data[m_cnt] = d;
      m_cnt++;
   endtask

   task automatic run(input logic [63:0] va, input logic [43:0] root,
                      input bit efault, input logic [55:0] epa, input logic [9:0] efl,
                      input int ereads, input logic [55:0] e0, e1, e2, input string tag);
      int n;
      logic [55:0] ex [3];
      ex[0] = e0; ex[1] = e1; ex[2] = e2;
      rd_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; root_ppn = root;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R8", "ready while busy", 64'(req_ready), 64'h0);
      n = 0;
      while (!res_valid && n < 300) begin
         @(negedge clk);
         n++;
      end
      chk(res_valid, tag, "result valid", 64'(res_valid), 64'h1);
      chk(res_fault == efault, tag, "fault", 64'(res_fault), 64'(efault));
      chk(res_paddr == epa, tag, "paddr", 64'(res_paddr), 64'(epa));
      chk(res_flags == efl, tag, "flags", 64'(res_flags), 64'(efl));
      chk(rd_cnt == ereads, tag, "read count", 64'(rd_cnt), 64'(ereads));
      for (int i = 0; i < 3; i++) begin
         if (i < ereads && i < rd_cnt)
            chk(rd_log[i] == ex[i], "R2", "entry address", 64'(rd_log[i]), 64'(ex[i]));
      end
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
      chk(req_ready && !res_valid, "R8", "idle after ack", 64'(req_ready), 64'h1);
   endtask

   // standard map: root 0x80001, indices 2/0x1A3/0x0FF
   task automatic map_a(input logic [9:0] f2, f1, f0);
      clear_mem();
      put(ea(44'h80001, 9'h002), mkpte(10'h0, 44'h80010, f2));
      put(ea(44'h80010, 9'h1A3), mkpte(10'h0, 44'h80020, f1));
      put(ea(44'h80020, 9'h0FF), mkpte(10'h0, 44'h12345, f0));
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R9", "reset ready", 64'(req_ready), 64'h1);
      chk(!mem_req_valid, "R9", "reset mem req", 64'(mem_req_valid), 64'h0);
      chk(!res_valid, "R9", "reset result", 64'(res_valid), 64'h0);
   endtask

   task automatic t_success();
      map_a(10'h001, 10'h001, 10'h0CF);
      run(mkva(9'h002, 9'h1A3, 9'h0FF, 12'hABC), 44'h80001, 1'b0, {44'h12345, 12'hABC}, 10'h0CF, 3,
          ea(44'h80001, 9'h002), ea(44'h80010, 9'h1A3), ea(44'h80020, 9'h0FF), "R6");
   endtask

   task automatic t_edges();
      // max indices, full-width page numbers, reserved bits set (R3)
      clear_mem();
      put(ea(44'hFFFFFFFFFFF, 9'h1FF), mkpte(10'h3FF, 44'h8000000000F, 10'h001));
      put(ea(44'h8000000000F, 9'h1FF), mkpte(10'h3FF, 44'h00000000001, 10'h3C1));
      put(ea(44'h00000000001, 9'h000), mkpte(10'h3FF, 44'hFEDCBA98765, 10'h3FF));
      run(mkva(9'h1FF, 9'h1FF, 9'h000, 12'hFFF), 44'hFFFFFFFFFFF, 1'b0, {44'hFEDCBA98765, 12'hFFF},
          10'h3FF, 3, ea(44'hFFFFFFFFFFF, 9'h1FF), ea(44'h8000000000F, 9'h1FF),
          ea(44'h00000000001, 9'h000), "R3");
   endtask

   task automatic t_canon();
      map_a(10'h001, 10'h001, 10'h0CF);
      run(mkva(9'h002, 9'h1A3, 9'h0FF, 12'h010) | (64'h1 << 39), 44'h80001, 1'b1, '0, '0, 0,
          '0, '0, '0, "R1");
      run(mkva(9'h002, 9'h1A3, 9'h0FF, 12'h010) | (64'h1 << 63), 44'h80001, 1'b1, '0, '0, 0,
          '0, '0, '0, "R1");
   endtask

   task automatic t_invalid();
      map_a(10'h0CE, 10'h001, 10'h0CF);
      run(mkva(9'h002, 9'h1A3, 9'h0FF, 12'h0), 44'h80001, 1'b1, '0, '0, 1,
          ea(44'h80001, 9'h002), '0, '0, "R4");
      map_a(10'h001, 10'h3FE, 10'h0CF);
      run(mkva(9'h002, 9'h1A3, 9'h0FF, 12'h0), 44'h80001, 1'b1, '0, '0, 2,
          ea(44'h80001, 9'h002), ea(44'h80010, 9'h1A3), '0, "R4");
      map_a(10'h001, 10'h001, 10'h3FE);
      run(mkva(9'h002, 9'h1A3, 9'h0FF, 12'h0), 44'h80001, 1'b1, '0, '0, 3,
          ea(44'h80001, 9'h002), ea(44'h80010, 9'h1A3), ea(44'h80020, 9'h0FF), "R5");
   endtask

   task automatic t_stall();
      mem_stall = 1'b1;
      map_a(10'h001, 10'h001, 10'h0C7);
      run(mkva(9'h002, 9'h1A3, 9'h0FF, 12'h5A5), 44'h80001, 1'b0, {44'h12345, 12'h5A5}, 10'h0C7, 3,
          ea(44'h80001, 9'h002), ea(44'h80010, 9'h1A3), ea(44'h80020, 9'h0FF), "R7");
      mem_stall = 1'b0;
   endtask

   task automatic t_hold();
      int n;
      map_a(10'h001, 10'h001, 10'h0CF);
      rd_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = mkva(9'h002, 9'h1A3, 9'h0FF, 12'h123); root_ppn = 44'h80001;
      @(negedge clk);
      req_vaddr = mkva(9'h002, 9'h1A3, 9'h0FF, 12'h777);
      n = 0;
      while (!res_valid && n < 300) begin
         @(negedge clk);
         n++;
      end
      repeat (5) @(negedge clk);
      chk(res_valid && res_paddr == {44'h12345, 12'h123}, "R8", "held result",
          64'(res_paddr), 64'({44'h12345, 12'h123}));
      chk(rd_cnt == 3, "R8", "no second walk", 64'(rd_cnt), 64'd3);
      req_valid = 1'b0;
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk(req_ready && !res_valid && rd_cnt == 3, "R8", "idle, offered request ignored",
          64'(rd_cnt), 64'd3);
   endtask

   task automatic t_reset_mid();
      int n;
      map_a(10'h001, 10'h001, 10'h0CF);
      rd_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = mkva(9'h002, 9'h1A3, 9'h0FF, 12'h0); root_ppn = 44'h80001;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (rd_cnt < 2 && n < 100) begin
         @(negedge clk);
         n++;
      end
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(req_ready && !mem_req_valid && !res_valid, "R9", "idle in reset mid-walk",
          64'(req_ready), 64'h1);
      rst = 1'b0;
      t_success();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_success();
      t_edges();
      t_canon();
      t_invalid();
      t_stall();
      t_hold();
      t_reset_mid();
      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule